// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a small counter with two count strobes instead of a clock plus a direction bit. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. A strobe only counts while the other strobe rests high. A parameter picks the modulus: decimal digit (0 to 9) or full binary (0 to 15 for four bits). A master clear and an active-low preset load override counting at once, without waiting for any strobe. Two active-low terminal flags, carry and borrow, let stages be chained: the carry of one stage drives the up strobe of the next, and the borrow drives its down strobe.

Both strobes are treated as asynchronous signals. A free-running system clock samples them, and a count happens on a detected rising edge. Clear and load reach the count output combinationally. The register underneath captures their value on the next clock, and a short synchronized hold window covers their release. In decimal mode, a code from 10 to 15 that was loaded or found in the register goes back into the legal sequence on the next count.

Top module: `updn_strobe_counter`

## Requirements
- R1: While `clr` is high, `count` reads zero in the same cycle, whatever `load_n`, `preset` and the strobes are doing. After `clr` drops, the count stays zero until a strobe counts.
- R2: While `load_n` is low and `clr` is low, `count` shows `preset` at once, and toggling the strobes has no effect. After `load_n` returns high, the loaded value stays.
- R3: A rising edge on `up_stb` while `dn_stb` stays high adds one. The maximum (9 in decimal mode, all ones in binary mode) wraps to 0.
- R4: A rising edge on `dn_stb` while `up_stb` stays high subtracts one. Zero wraps to the maximum.
- R5: If both strobes rise in the same sample, or one strobe rises while the other is low, the count holds.
- R6: A single strobe rising edge produces exactly one step, however long the strobe then stays high.
- R7: `carry_n` is 0 exactly when the count equals the maximum and the synchronized up strobe is low. Otherwise it is 1.
- R8: `borrow_n` is 0 exactly when the count is zero and the synchronized down strobe is low. Otherwise it is 1.
- R9: In decimal mode, a code from 10 to 15 goes to 0 on an up count and to 9 on a down count.
- R10: In binary mode, all codes 0 to 15 are legal, and counting wraps between 15 and 0.
- R11: Two decimal stages can be chained (carry to the next up strobe, borrow to the next down strobe) and then count as a two-digit value from 00 to 99 in both directions.
- R12: Strobes pass through a two-flop synchronizer. The count changes on the third system clock rising edge after the strobe rises, and not before.
- R13: While `rst_n` is low at a clock edge, the count clears to zero and both flags read 1 with the strobes idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Master clear, active high, acts immediately |
| load_n | input | 1 | Preset load, active low, acts immediately |
| preset | input | CNT_W | Value taken while load is asserted |
| up_stb | input | 1 | Count-up strobe; counts on its rising edge |
| dn_stb | input | 1 | Count-down strobe; counts on its rising edge |
| count | output | CNT_W | Present count |
| carry_n | output | 1 | Low at the maximum while the up strobe is low |
| borrow_n | output | 1 | Low at zero while the down strobe is low |

## Verification
The assertions check the following properties on every cycle:
- the clear and load outcome on the register;
- that the count stays still when no qualified edge arrives;
- that a strobe never yields two rises in a row;
- that the flags fall only at the matching terminal count;
- that an illegal decimal code leaves the illegal range after one step.

Only the bench scenarios can show the following:
- the exact three-edge latency from strobe to count;
- the wrap values in both moduli;
- recovery from each illegal code;
- whether strobe toggles made during a load are really ignored;
- a two-stage chain rolling over from 99 to 00 and back.

// File: rtl/updn_cnt_pkg.sv
// Package: shared step encoding for the dual-strobe counter.
// Assumes: nothing beyond IEEE 1800-2017.
package updn_cnt_pkg;

    // Decision taken for one system clock cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

endpackage

// File: rtl/updn_sync_chain.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; RST_VAL is the idle level of the input so that
// reset does not manufacture a transition.
module updn_sync_chain #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stage_q;

    // First stage: capture the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= async_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stages: let a metastable sample settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= RST_VAL;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/updn_strobe_edge.sv
// Module: synchronizes one count strobe and flags its rising edge.
// Assumes: the strobe idles high, so every stage resets to 1.
module updn_strobe_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic rise_o
);

    logic prev_q;

    updn_sync_chain #(
        .STAGES  (STAGES),
        .RST_VAL (1'b1)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_i),
        .sync_o  (level_o)
    );

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;

    // One strobe edge must never be seen as two back-to-back rises.
    assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/updn_count_core.sv
// Module: count register with clear, load, hold window and modulus logic.
// Assumes: clr/load_n are raw asynchronous controls that are held for at
// least one clock; hold_i is their synchronized OR that covers release.
module updn_count_core
    import updn_cnt_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter bit          DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             hold_i,
    input  logic             up_lvl,
    input  logic             up_rise,
    input  logic             dn_lvl,
    input  logic             dn_rise,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    step_e            step;
    logic [CNT_W-1:0] inc_val;
    logic [CNT_W-1:0] dec_val;

    // Pick the step: a lone rise while the other strobe rests high.
    always_comb begin
        step = STEP_HOLD;
        if (up_rise && !dn_rise && dn_lvl)      step = STEP_INC;
        else if (dn_rise && !up_rise && up_lvl) step = STEP_DEC;
    end

    // Next values with wrap; codes above the maximum fold back in one step.
    always_comb begin
        inc_val = (count_q >= CNT_MAX) ? '0 : count_q + 1'b1;
        dec_val = (count_q == '0 || count_q > CNT_MAX) ? CNT_MAX : count_q - 1'b1;
    end

    // Count register: reset, clear, load, release hold, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clr)     count_q <= '0;
        else if (!load_n) count_q <= preset;
        else if (hold_i)  count_q <= count_q;
        else begin
            case (step)
                STEP_INC: count_q <= inc_val;
                STEP_DEC: count_q <= dec_val;
                default:  count_q <= count_q;
            endcase
        end
    end

    // R1: clear lands zero in the register.
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

    // R2: load captures the preset seen at that edge.
    assert_load_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (count_q == $past(preset)));

    // R5: without a qualified edge or override, the count stays put.
    assert_hold_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && (hold_i || (up_rise && dn_rise) || (up_rise && !dn_lvl)
          || (dn_rise && !up_lvl) || (!up_rise && !dn_rise)))
        |=> $stable(count_q));

    // R9: an out-of-range code is gone after one counted step.
    assert_illegal_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && !hold_i && step != STEP_HOLD && count_q > CNT_MAX)
        |=> (count_q <= CNT_MAX));

endmodule

// File: rtl/updn_strobe_counter.sv
// Module: top of the dual-strobe presettable up/down counter.
// Assumes: strobes idle high and are asynchronous to clk; clr and load_n
// act combinationally on the output and are held for at least one clock.
module updn_strobe_counter #(
    parameter int unsigned CNT_W       = 4,
    parameter bit          DECADE      = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [CNT_W-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [CNT_W-1:0] CNT_MAX = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    logic             up_lvl, up_rise;
    logic             dn_lvl, dn_rise;
    logic             ovr_hold;
    logic [CNT_W-1:0] count_q;

    updn_strobe_edge #(.STAGES(SYNC_STAGES)) u_up_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (up_stb),
        .level_o  (up_lvl),
        .rise_o   (up_rise)
    );

    updn_strobe_edge #(.STAGES(SYNC_STAGES)) u_dn_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (dn_stb),
        .level_o  (dn_lvl),
        .rise_o   (dn_rise)
    );

    updn_sync_chain #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_ovr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (clr | ~load_n),
        .sync_o  (ovr_hold)
    );

    updn_count_core #(
        .CNT_W  (CNT_W),
        .DECADE (DECADE)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load_n  (load_n),
        .preset  (preset),
        .hold_i  (ovr_hold),
        .up_lvl  (up_lvl),
        .up_rise (up_rise),
        .dn_lvl  (dn_lvl),
        .dn_rise (dn_rise),
        .count_q (count_q)
    );

    // Output view: clear and load reach the pins without a clock.
    always_comb begin
        if (clr)          count = '0;
        else if (!load_n) count = preset;
        else              count = count_q;
    end

    // Terminal flags: low at the end of range during the strobe's low half.
    always_comb begin
        carry_n  = ~((count == CNT_MAX) && !up_lvl);
        borrow_n = ~((count == '0) && !dn_lvl);
    end

    // R7: carry only falls at the maximum with the up strobe low.
    assert_carry_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == CNT_MAX && !up_lvl));

    // R8: borrow only falls at zero with the down strobe low.
    assert_borrow_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0 && !dn_lvl));

endmodule

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic       c_up = 1'b1;
    logic       c_dn = 1'b1;

    logic [3:0] d_cnt, b_cnt, lo_cnt, hi_cnt;
    logic       d_cy, d_bw, b_cy, b_bw, lo_cy, lo_bw, hi_cy, hi_bw;

    int errors = 0;
    int checks = 0;
    int m_dec = 0;
    int m_bin = 0;
    int m_casc = 0;
    bit lvl_up = 1'b1;
    bit lvl_dn = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    updn_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up), .dn_stb(dn), .count(d_cnt), .carry_n(d_cy), .borrow_n(d_bw));

    updn_strobe_counter #(.CNT_W(4), .DECADE(1'b0)) u_bin (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up), .dn_stb(dn), .count(b_cnt), .carry_n(b_cy), .borrow_n(b_bw));

    updn_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) u_lo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(1'b1), .preset(4'd0),
        .up_stb(c_up), .dn_stb(c_dn), .count(lo_cnt), .carry_n(lo_cy), .borrow_n(lo_bw));

    updn_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(1'b1), .preset(4'd0),
        .up_stb(lo_cy), .dn_stb(lo_bw), .count(hi_cnt), .carry_n(hi_cy), .borrow_n(hi_bw));

    function automatic int f_up(int v, int mx);
        return (v >= mx) ? 0 : v + 1;
    endfunction

    function automatic int f_dn(int v, int mx);
        return (v == 0 || v > mx) ? mx : v - 1;
    endfunction

    function automatic int f_flag(bit at_end, bit lvl);
        return (at_end && !lvl) ? 0 : 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_main(string req);
        chk(req, d_cnt, m_dec);
        chk("R10", b_cnt, m_bin);
        chk("R7", d_cy, f_flag(m_dec == 9, lvl_up));
        chk("R8", d_bw, f_flag(m_dec == 0, lvl_dn));
        chk("R7", b_cy, f_flag(m_bin == 15, lvl_up));
        chk("R8", b_bw, f_flag(m_bin == 0, lvl_dn));
    endtask

    // Set both strobe levels, let them settle, update models, check.
    task automatic drive(bit nu, bit nd);
        bit    ur, dr;
        string req;
        ur = nu & !lvl_up;
        dr = nd & !lvl_dn;
        up = nu;
        dn = nd;
        repeat (4) @(negedge clk);
        req = (ur || dr) ? "R5" : "R6";
        if (ur && !dr && nd) begin
            req = (m_dec > 9) ? "R9" : "R3";
            m_dec = f_up(m_dec, 9);
            m_bin = f_up(m_bin, 15);
        end else if (dr && !ur && nu) begin
            req = (m_dec > 9) ? "R9" : "R4";
            m_dec = f_dn(m_dec, 9);
            m_bin = f_dn(m_bin, 15);
        end
        lvl_up = nu;
        lvl_dn = nd;
        chk_main(req);
    endtask

    task automatic do_load(int p, bit toggle);
        preset = 4'(p);
        load_n = 1'b0;
        #1;
        chk("R2", d_cnt, p);
        chk("R2", b_cnt, p);
        repeat (3) @(negedge clk);
        if (toggle) begin
            up = 1'b0;
            repeat (3) @(negedge clk);
            up = 1'b1;
            repeat (3) @(negedge clk);
            chk("R2", d_cnt, p);
        end
        load_n = 1'b1;
        preset = 4'(p + 3);
        repeat (4) @(negedge clk);
        m_dec = p;
        m_bin = p;
        chk_main("R2");
    endtask

    task automatic do_clear(bit with_load);
        clr = 1'b1;
        if (with_load) begin
            load_n = 1'b0;
            preset = 4'd5;
        end
        #1;
        chk("R1", d_cnt, 0);
        chk("R1", b_cnt, 0);
        repeat (3) @(negedge clk);
        clr = 1'b0;
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        m_dec = 0;
        m_bin = 0;
        m_casc = 0;
        chk_main("R1");
        chk("R1", lo_cnt, 0);
        chk("R1", hi_cnt, 0);
    endtask

    task automatic casc_step(bit is_up);
        int lo, hi, lo_f, hi_f;
        lo = m_casc % 10;
        hi = m_casc / 10;
        if (is_up) c_up = 1'b0; else c_dn = 1'b0;
        repeat (6) @(negedge clk);
        if (is_up) begin
            lo_f = f_flag(lo == 9, 1'b0);
            hi_f = f_flag(hi == 9, lo_f[0]);
            chk("R11", lo_cy, lo_f);
            chk("R11", hi_cy, hi_f);
        end else begin
            lo_f = f_flag(lo == 0, 1'b0);
            hi_f = f_flag(hi == 0, lo_f[0]);
            chk("R11", lo_bw, lo_f);
            chk("R11", hi_bw, hi_f);
        end
        c_up = 1'b1;
        c_dn = 1'b1;
        repeat (6) @(negedge clk);
        m_casc = is_up ? (m_casc + 1) % 100 : (m_casc + 99) % 100;
        chk("R11", lo_cnt, m_casc % 10);
        chk("R11", hi_cnt, m_casc / 10);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state.
        chk("R13", d_cnt, 0);
        chk("R13", d_cy, 1);
        chk("R13", d_bw, 1);
        chk("R13", lo_cnt, 0);

        // R12: strobe-to-count latency of three clock edges.
        drive(1'b0, 1'b1);
        up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12", d_cnt, 0);
        @(negedge clk);
        chk("R12", d_cnt, 1);
        @(negedge clk);
        lvl_up = 1'b1;
        m_dec = 1;
        m_bin = 1;
        chk_main("R3");

        // R6: holding high adds no more counts.
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);

        // R3/R7: wrap at nine, carry low in the low half.
        do_load(9, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);

        // R4/R8: wrap at zero, borrow low in the low half.
        do_load(0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);

        // R9/R10: illegal decimal codes and binary wrap.
        do_load(12, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        do_load(14, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        do_load(15, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);

        // R5: both rise together; one rises while the other is low.
        do_load(4, 1'b0);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);

        // R2: strobe activity during a load is ignored.
        do_load(6, 1'b1);

        // R1: clear wins over a simultaneous load.
        do_clear(1'b1);

        // Constrained random mix.
        for (int i = 0; i < 250; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0)      do_load(int'($urandom % 16), 1'b0);
            else if (r == 1) do_clear(1'b0);
            else             drive(1'($urandom), 1'($urandom));
        end
        drive(1'b1, 1'b1);

        // R11: two chained decimal stages through 99 and back.
        do_clear(1'b0);
        for (int i = 0; i < 105; i++) casc_step(1'b1);
        for (int i = 0; i < 8; i++) casc_step(1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule